// File: doc/BRIEF.md
# Subword-parallel SIMD ALU lane

This block is a 32-bit arithmetic slice that views each operand word as a set of packed lanes. The caller picks the lane width for each operation: four 8-bit lanes, two 16-bit lanes, or one 32-bit lane. The slice offers four operations. It can add lane by lane, AND the two words, shift each lane left by one bit, or shift each lane right by one bit. A fourth width setting joins the slice to a neighbour to form a 64-bit word. In that chained mode an external carry enters at bit 0 and an external shift-in enters at bit 31.

Each operation starts with a one-cycle start pulse, and the operands are captured on that edge. A small sequencer counts out a fixed latency: 4 clocks in the lane modes and 8 in the chained mode. The result and the carry output then update, and the valid flag pulses for one cycle. Both outputs hold their value until the next operation completes. A start pulse that arrives while an operation is running is dropped.

Top module: `simd_alu_lane`

## Requirements
- R1: In reset (synchronous, active high) the result, the carry output and the valid flag all read 0. The opcode values are add = 4'b0000, AND = 4'b1000, shift left = 4'b1100 and shift right = 4'b1110. The width select values are 2'b00 for 8-bit lanes, 2'b01 for 16-bit lanes, 2'b10 for one 32-bit lane and 2'b11 for the chained 64-bit mode.
- R2: In add with width 00, 01 or 10, each lane gives the sum of its two operand lanes modulo 2^lane-width. No carry passes from one lane into the next, and the carry input has no effect.
- R3: In add, the carry output is the carry out of the most significant lane.
- R4: In chained mode, add computes a + b + carry input over the full 32 bits, and the carry output is the carry out of bit 31.
- R5: Shift left moves each lane up by one bit. The lowest bit of each lane is filled with 0, except in chained mode, where bit 0 takes the carry input. The carry output is operand bit 31.
- R6: Shift right moves each lane down by one bit. The highest bit of each lane is filled with 0, except in chained mode, where bit 31 takes the right-shift input. In all other modes the right-shift input has no effect. The carry output is operand bit 0.
- R7: AND gives the bitwise AND of the two operands at every width setting, and the carry output is 0.
- R8: Any opcode other than the four listed gives a result of 0 and a carry output of 0.
- R9: The valid flag goes high 4 clocks after the edge that accepts a start in widths 00, 01 and 10, and 8 clocks after it in width 11.
- R10: The valid flag stays high for exactly one cycle. The result and the carry output change only on the edge where valid rises, and they hold their value at all other times.
- R11: A start pulse that arrives while an operation is in progress is ignored. It does not change the running operation's result or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; operands are captured on the accepting edge |
| op_code | input | 4 | Operation select |
| lane_sel | input | 2 | Lane width or chained mode select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| link_cin | input | 1 | Carry from the neighbouring slice (chained mode only) |
| link_rsin | input | 1 | Shift-in bit for bit 31 (chained mode only) |
| res | output | 32 | Registered result |
| cout | output | 1 | Registered carry output |
| res_valid | output | 1 | One-cycle pulse when a new result is presented |

## Verification
The add path is driven with byte values that overflow in some lanes but not in others. This shows whether carries are cut at lane boundaries, and whether the carry output comes from the top lane rather than from the whole word. The same operand pairs are run at all four width settings, with the carry and shift-in inputs set to 1. A leak of those inputs into lane modes, or a chained mode that drops them, then changes the result. Random operands, opcodes outside the defined set, and start pulses that overlap a running operation are compared against a behavioural model on every clock. Any early or late valid pulse, and any change to the output while no result is due, shows up as a mismatch.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam logic [3:0] OPC_ADD = 4'b0000;
  localparam logic [3:0] OPC_AND = 4'b1000;
  localparam logic [3:0] OPC_SHL = 4'b1100;
  localparam logic [3:0] OPC_SHR = 4'b1110;

  localparam logic [1:0] WID_B8    = 2'b00;
  localparam logic [1:0] WID_B16   = 2'b01;
  localparam logic [1:0] WID_B32   = 2'b10;
  localparam logic [1:0] WID_CHAIN = 2'b11;
endpackage

// File: rtl/simd_alu_seq.sv
module simd_alu_seq #(
  parameter int LAT_LANE  = 4,
  parameter int LAT_CHAIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic chain,
  output logic accept,
  output logic done
);
  localparam int CW = $clog2(LAT_CHAIN + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tgt_q;

  assign accept = start & ~busy;
  assign done   = busy && (cnt == tgt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      tgt_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= CW'(1);
      tgt_q <= chain ? CW'(LAT_CHAIN) : CW'(LAT_LANE);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/simd_alu_core.sv
module simd_alu_core
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NARROW = 8,
  parameter int MID    = 16
) (
  input  logic [3:0]        op,
  input  logic [1:0]        wsel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              rsin,
  output logic [DATA_W-1:0] y,
  output logic              cy
);
  logic              chain, m_n, m_m;
  logic [DATA_W-1:0] lo_edge, hi_edge, cbit, sum, shl, shr;
  logic [DATA_W:1]   car;

  assign chain = (wsel == WID_CHAIN);
  assign m_n   = (wsel == WID_B8);
  assign m_m   = (wsel == WID_B16);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign lo_edge[g] = (g == 0) || (m_n && (g % NARROW == 0)) || (m_m && (g % MID == 0));
    assign hi_edge[g] = (g == DATA_W - 1) || (m_n && (g % NARROW == NARROW - 1)) ||
                        (m_m && (g % MID == MID - 1));
    if (g == 0) begin : g_lo
      assign cbit[g] = chain & cin;
      assign shl[g]  = chain & cin;
    end else begin : g_mid
      assign cbit[g] = lo_edge[g] ? 1'b0 : car[g];
      assign shl[g]  = lo_edge[g] ? 1'b0 : a[g-1];
    end
    if (g == DATA_W - 1) begin : g_hi
      assign shr[g] = chain & rsin;
    end else begin : g_low
      assign shr[g] = hi_edge[g] ? 1'b0 : a[g+1];
    end
    assign sum[g]   = a[g] ^ b[g] ^ cbit[g];
    assign car[g+1] = (a[g] & b[g]) | (cbit[g] & (a[g] ^ b[g]));
  end

  always_comb begin
    case (op)
      OPC_ADD: begin y = sum;   cy = car[DATA_W];  end
      OPC_AND: begin y = a & b; cy = 1'b0;        end
      OPC_SHL: begin y = shl;   cy = a[DATA_W-1]; end
      OPC_SHR: begin y = shr;   cy = a[0];        end
      default: begin y = '0;    cy = 1'b0;        end
    endcase
  end
endmodule

// File: rtl/simd_alu_lane.sv
module simd_alu_lane
  import simd_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LAT_LANE  = 4,
  parameter int LAT_CHAIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        op_code,
  input  logic [1:0]        lane_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              link_cin,
  input  logic              link_rsin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              res_valid
);
  logic              accept, done;
  logic [3:0]        op_q;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] a_q, b_q, y;
  logic              cin_q, rsin_q, cy;

  simd_alu_seq #(.LAT_LANE(LAT_LANE), .LAT_CHAIN(LAT_CHAIN)) u_seq (
    .clk(clk), .rst(rst), .start(start), .chain(lane_sel == WID_CHAIN),
    .accept(accept), .done(done)
  );

  simd_alu_core #(.DATA_W(DATA_W)) u_core (
    .op(op_q), .wsel(sel_q), .a(a_q), .b(b_q), .cin(cin_q), .rsin(rsin_q),
    .y(y), .cy(cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      sel_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      cin_q  <= 1'b0;
      rsin_q <= 1'b0;
    end else if (accept) begin
      op_q   <= op_code;
      sel_q  <= lane_sel;
      a_q    <= opa;
      b_q    <= opb;
      cin_q  <= link_cin;
      rsin_q <= link_rsin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      cout      <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= done;
      if (done) begin
        res  <= y;
        cout <= cy;
      end
    end
  end
endmodule

// File: rtl/simd_alu_lane_chk.sv
module simd_alu_lane_chk
  import simd_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LAT_LANE  = 4,
  parameter int LAT_CHAIN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [3:0]        op_code,
  input logic [1:0]        lane_sel,
  input logic [DATA_W-1:0] res,
  input logic              cout,
  input logic              res_valid
);
  logic       cb, fire, arm;
  int         cc, cl;
  logic [3:0] cop;

  always_ff @(posedge clk) begin
    if (rst) begin
      cb <= 1'b0; fire <= 1'b0; arm <= 1'b0; cc <= 0; cl <= 0; cop <= '0;
    end else begin
      arm  <= 1'b1;
      fire <= 1'b0;
      if (cb) begin
        cc <= cc + 1;
        if (cc + 1 == cl) begin
          cb   <= 1'b0;
          fire <= 1'b1;
        end
      end else if (start) begin
        cb  <= 1'b1;
        cc  <= 0;
        cl  <= (lane_sel == WID_CHAIN) ? LAT_CHAIN : LAT_LANE;
        cop <= op_code;
      end
    end
  end

  AST_VALID_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    fire |-> res_valid); // R9
  AST_VALID_ONLY_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> fire); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R10
  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (arm && !res_valid) |-> ($stable(res) && $stable(cout))); // R10
  AST_AND_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (res_valid && cop == OPC_AND) |-> !cout); // R7
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_valid && cop != OPC_ADD && cop != OPC_AND && cop != OPC_SHL && cop != OPC_SHR)
      |-> (res == '0 && !cout)); // R8
endmodule

bind simd_alu_lane simd_alu_lane_chk #(
  .DATA_W(DATA_W), .LAT_LANE(LAT_LANE), .LAT_CHAIN(LAT_CHAIN)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_code(op_code), .lane_sel(lane_sel),
  .res(res), .cout(cout), .res_valid(res_valid)
);

// File: tb/simd_alu_lane_bench.sv
module simd_alu_lane_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op_code = '0;
  logic [1:0]  lane_sel = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        link_cin = 1'b0, link_rsin = 1'b0;
  logic [31:0] res;
  logic        cout, res_valid;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic cmp_en = 1'b0;

  always #4 clk = ~clk;

  simd_alu_lane u_simd_alu_lane (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code), .lane_sel(lane_sel),
    .opa(opa), .opb(opb), .link_cin(link_cin), .link_rsin(link_rsin),
    .res(res), .cout(cout), .res_valid(res_valid)
  );

  function automatic logic [32:0] ref_calc(input logic [3:0] op, input logic [1:0] w,
      input logic [31:0] a, input logic [31:0] b, input logic ci, input logic ri);
    int lw, n;
    longint unsigned msk, la, lb, s, wa, wb;
    logic [31:0] r;
    logic c, ch;
    ch = (w == 2'b11);
    lw = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    n = 32 / lw;
    msk = (64'd1 << lw) - 64'd1;
    wa = {32'd0, a};
    wb = {32'd0, b};
    r = '0;
    c = 1'b0;
    if (op == 4'b1000) return {1'b0, a & b};
    if (op != 4'b0000 && op != 4'b1100 && op != 4'b1110) return 33'd0;
    for (int k = 0; k < n; k++) begin
      la = (wa >> (k * lw)) & msk;
      lb = (wb >> (k * lw)) & msk;
      if (op == 4'b0000) begin
        s = la + lb + ((ch && ci) ? 64'd1 : 64'd0);
        if (k == n - 1) c = s[lw];
      end else if (op == 4'b1100) begin
        s = (la << 1) | ((ch && ci) ? 64'd1 : 64'd0);
        if (k == n - 1) c = la[lw-1];
      end else begin
        s = (la >> 1) | ((ch && ri) ? (64'd1 << (lw - 1)) : 64'd0);
        c = a[0];
      end
      s = s & msk;
      r = r | 32'(s << (k * lw));
    end
    return {c, r};
  endfunction

  // behavioural reference: countdown per accepted start
  logic        m_busy = 1'b0, m_valid = 1'b0, m_cout = 1'b0;
  int          m_left = 0;
  logic [31:0] m_res = '0, m_a, m_b;
  logic [3:0]  m_op;
  logic [1:0]  m_w;
  logic        m_ci, m_ri;
  string       m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_valid = 1'b0; m_res = '0; m_cout = 1'b0; m_tag = "R1";
    end else begin
      m_valid = 1'b0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          {m_cout, m_res} = ref_calc(m_op, m_w, m_a, m_b, m_ci, m_ri);
          m_valid = 1'b1;
          m_busy  = 1'b0;
          case (m_op)
            4'b0000: m_tag = (m_w == 2'b11) ? "R4" : "R2/R3";
            4'b1000: m_tag = "R7";
            4'b1100: m_tag = "R5";
            4'b1110: m_tag = "R6";
            default: m_tag = "R8";
          endcase
        end
      end else if (start) begin
        m_busy = 1'b1;
        m_left = (lane_sel == 2'b11) ? 8 : 4;
        m_op = op_code; m_w = lane_sel; m_a = opa; m_b = opb;
        m_ci = link_cin; m_ri = link_rsin;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      check(m_valid ? "R9" : "R10/R11", "res_valid", {31'd0, res_valid}, {31'd0, m_valid});
      check(m_valid ? m_tag : "R10", "res", res, m_res);
      check(m_valid ? m_tag : "R10", "cout", {31'd0, cout}, {31'd0, m_cout});
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic ci, input logic ri, input int gap);
    @(negedge clk);
    op_code = op; lane_sel = w; opa = a; opb = b; link_cin = ci; link_rsin = ri;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] ops [5];
    ops[0] = 4'b0000; ops[1] = 4'b1000; ops[2] = 4'b1100; ops[3] = 4'b1110; ops[4] = 4'b0101;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;  // R1: reset state compared on this first cycle
    @(negedge clk);
    // R2 R3: lane adds, carry input set but ignored
    issue(4'b0000, 2'b00, 32'hFE5A3415, 32'h3EBB6849, 1'b1, 1'b0, 6);
    issue(4'b0000, 2'b01, 32'hF0A17E63, 32'h09C4A185, 1'b1, 1'b0, 6);
    issue(4'b0000, 2'b10, 32'hF0A17E63, 32'h09C4A185, 1'b1, 1'b0, 6);
    // R4: chained add
    issue(4'b0000, 2'b11, 32'hF0A17E63, 32'h09C4A185, 1'b1, 1'b0, 10);
    issue(4'b0000, 2'b11, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 10);
    // R7: AND at all widths
    for (int w = 0; w < 4; w++)
      issue(4'b1000, 2'(w), 32'h94DAE4EB, 32'hD6B55556, 1'b1, 1'b1, 10);
    // R5 R6: shifts at all widths with both link inputs set
    for (int w = 0; w < 4; w++) begin
      issue(4'b1100, 2'(w), 32'h95325BBB, 32'hFFFFFFFF, 1'b1, 1'b1, 10);
      issue(4'b1110, 2'(w), 32'h976B4992, 32'hFFFFFFFF, 1'b1, 1'b1, 10);
    end
    // R8: undefined opcode
    issue(4'b0111, 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 6);
    // R11: second start while busy is dropped
    issue(4'b0000, 2'b11, 32'h12345678, 32'h11111111, 1'b0, 1'b0, 1);
    issue(4'b1000, 2'b00, 32'hFFFFFFFF, 32'h0F0F0F0F, 1'b0, 1'b0, 10);
    // back-to-back starts, accepted right after completion
    issue(4'b0000, 2'b00, 32'h80808080, 32'h80808080, 1'b0, 1'b0, 3);
    issue(4'b1100, 2'b01, 32'h80018001, 32'h0, 1'b1, 1'b0, 6);
    void'($urandom(7));
    for (int k = 0; k < 60; k++)
      issue(ops[$urandom % 5], 2'($urandom % 4), $urandom, $urandom, 1'($urandom),
            1'($urandom), $urandom % 10);
    repeat (12) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule